// File: doc/BRIEF.md
# Framed-Stream Word Deserializer

This block sits on the receive side of a serial link. It takes a serial data line together with the bit clock forwarded by the transmitter, finds the word boundaries carried inside the stream, and presents each recovered word on a 24-bit parallel port. A companion word clock rises once for every word that passes its framing check. Frames with broken framing produce no word-clock pulse and leave the port untouched.

Each frame is 26 bits long, sent oldest first. It has a start bit (1), 22 data bits, two spare bits and a stop bit (0). The receiver searches every bit position for a start/stop pair, confirms the alignment with a second frame, and keeps the alignment through a single bad frame. It drops the alignment after two bad frames in a row.

Enable and reset come from the power controller. When enable rises, the word clock first goes through a fixed low pulse. After that it idles high and carries the word pulses. The direction input, sampled once after reset, decides whether the block acts as a receiver at all.

The controller has six states:
- OFF: powered down, word clock high.
- WAKE: the low pulse is being timed.
- HUNT: searching bit by bit for a start/stop pair.
- VERIFY: one candidate frame has been seen.
- LOCKED: aligned.
- SLIP: aligned, after one bad frame.

Its transitions are:
- OFF→WAKE on enable in the receiver role.
- WAKE→HUNT after 4 cycles.
- HUNT→VERIFY on a start/stop match.
- VERIFY→LOCKED on a good frame, and VERIFY→HUNT on a bad one.
- LOCKED→SLIP on a bad frame.
- SLIP→LOCKED on a good frame, and SLIP→HUNT on a bad one.
- any state→OFF when enable is low.

Top module: `framed_word_deser`

## Requirements
- R1: While rst_n is low, dout is all zeros and word_clk is high.
- R2: On the first bit_clk rising edge after reset release, dir_sel is captured. A value of 0 selects the receiver role. A value of 1 leaves the block idle, with word_clk high and dout unchanged, until the next reset. Later changes of dir_sel have no effect.
- R3: When en is high in the receiver role and the block is powered down, word_clk goes low for exactly 4 bit_clk cycles and then returns high.
- R4: A frame is 26 bits sampled on rising bit_clk edges, in this order: a start bit of 1, data bits 1 to 22, two spare bits whose values are ignored, and a stop bit of 0.
- R5: While searching, any bit position whose oldest bit is 1 and whose bit 25 positions later is 0 is taken as a candidate frame. That candidate produces no output. If the next 26 bits also frame correctly, lock is declared and that second frame is output.
- R6: Each good frame seen while confirming or locked updates dout. word_clk goes low for one cycle on the same edge and rises on the next edge. At every other time dout holds its value.
- R7: A frame with a wrong start or stop bit produces no word_clk pulse and leaves dout unchanged. After a single bad frame the alignment is kept, so the next good frame is output.
- R8: Two consecutive bad frames drop the lock. Searching restarts, and two good frames are again needed before any output.
- R9: dout[i] is word position i+1. Positions 1 to 20 (dout[19:0]) carry data bits 1 to 20. Positions 23 and 24 (dout[22], dout[23]) carry data bits 21 and 22. Positions 21 and 22 (dout[21:20]) are always 0.
- R10: When en is low, word_clk is high after the next edge and dout is held. Framing state is discarded, so re-enabling repeats R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Forwarded bit clock; serial data sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset from the power controller |
| en | input | 1 | Active-mode enable from the power controller |
| dir_sel | input | 1 | Role select, sampled once after reset (0 = receiver) |
| sdata | input | 1 | Serial data line |
| word_clk | output | 1 | Word clock; idles high, low for one cycle per good word |
| dout | output | 24 | Recovered word, positions 1..24 on bits 0..23 |

## Verification
If the controller holds the wrong alignment or the wrong lock state, the fault shows at the ports within one frame time (26 bit clocks). It appears as a word-clock pulse where none belongs, a missing pulse, or a dout value that is not the mapped payload of the last good frame. A wrong wake counter changes the length of the first low run on word_clk, so it is visible within the first few cycles after enable. A wrong role capture shows as pulses from a block that should stay idle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_WAKE   = 3'd1,
        ST_HUNT   = 3'd2,
        ST_VERIFY = 3'd3,
        ST_LOCKED = 3'd4,
        ST_SLIP   = 3'd5
    } rx_state_e;

endpackage

// File: rtl/fwd_window.sv
module fwd_window #(
    parameter int FRAME_LEN = 26,
    parameter int DATA_W    = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              sdata,
    output logic              frame_ok,
    output logic [DATA_W-1:0] payload
);

    logic [FRAME_LEN-1:0] win;

    // oldest bit sits at the top, newest at bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win <= '0;
        end else if (shift_en) begin
            win <= {win[FRAME_LEN-2:0], sdata};
        end
    end

    assign frame_ok = win[FRAME_LEN-1] & ~win[0];

    // data bit k (1-based) follows the start bit by k positions
    for (genvar k = 0; k < DATA_W; k++) begin : g_pay
        assign payload[k] = win[FRAME_LEN-2-k];
    end

endmodule

// File: rtl/fwd_posmap.sv
module fwd_posmap #(
    parameter int DATA_W = 22,
    parameter int GAP_LO = 20,
    parameter int GAP_N  = 2,
    parameter int OUT_W  = DATA_W + GAP_N
) (
    input  logic [DATA_W-1:0] payload,
    output logic [OUT_W-1:0]  word
);

    for (genvar i = 0; i < OUT_W; i++) begin : g_pos
        if (i < GAP_LO) begin : g_low
            assign word[i] = payload[i];
        end else if (i < GAP_LO + GAP_N) begin : g_gap
            assign word[i] = 1'b0;
        end else begin : g_high
            assign word[i] = payload[i-GAP_N];
        end
    end

endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
    import fwd_pkg::*;
#(
    parameter int FRAME_LEN = 26,
    parameter int WAKE_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dir_sel,
    input  logic frame_ok,
    output logic take,
    output logic wclk
);

    localparam int PH_W = $clog2(FRAME_LEN);
    localparam int WK_W = $clog2(WAKE_CYC + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_LEN - 1);
    localparam logic [WK_W-1:0] WK_LAST = WK_W'(WAKE_CYC - 1);

    rx_state_e       state, nxt;
    logic [PH_W-1:0] phase;
    logic [WK_W-1:0] wake_cnt;
    logic            role_set, role_rx;
    logic            boundary, in_frame;

    assign boundary = (phase == PH_LAST);
    assign in_frame = (state == ST_VERIFY) || (state == ST_LOCKED) || (state == ST_SLIP);
    assign take     = en && in_frame && boundary && frame_ok;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:    if (en && role_set && role_rx) nxt = ST_WAKE;
            ST_WAKE:   if (wake_cnt == WK_LAST) nxt = ST_HUNT;
            ST_HUNT:   if (frame_ok) nxt = ST_VERIFY;
            ST_VERIFY: if (boundary) nxt = frame_ok ? ST_LOCKED : ST_HUNT;
            ST_LOCKED: if (boundary && !frame_ok) nxt = ST_SLIP;
            ST_SLIP:   if (boundary) nxt = frame_ok ? ST_LOCKED : ST_HUNT;
            default:   nxt = ST_OFF;
        endcase
        if (!en) nxt = ST_OFF;
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            phase    <= '0;
            wake_cnt <= '0;
            role_set <= 1'b0;
            role_rx  <= 1'b0;
        end else begin
            state <= nxt;
            if (!role_set) begin
                role_set <= 1'b1;
                role_rx  <= ~dir_sel;
            end
            if (state == ST_WAKE) wake_cnt <= wake_cnt + 1'b1;
            else                  wake_cnt <= '0;
            if (in_frame && !boundary) phase <= phase + 1'b1;
            else                       phase <= '0;
        end
    end

    // word clock output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wclk <= 1'b1;
        end else begin
            wclk <= !(nxt == ST_WAKE) && !take;
        end
    end

    assert_off_clk_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> wclk);

    assert_wake_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> (!wclk && wake_cnt < WK_W'(WAKE_CYC)));

    assert_lock_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED && $past(state) != ST_LOCKED)
            |-> ($past(state) == ST_VERIFY || $past(state) == ST_SLIP));

    assert_role_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (role_set && !role_rx) |-> (state == ST_OFF));

    assert_hunt_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && $past(state) == ST_SLIP) |-> !$past(frame_ok));

endmodule

// File: rtl/framed_word_deser.sv
module framed_word_deser #(
    parameter int FRAME_LEN = 26,
    parameter int DATA_W    = 22,
    parameter int GAP_LO    = 20,
    parameter int GAP_N     = 2,
    parameter int WAKE_CYC  = 4,
    parameter int OUT_W     = DATA_W + GAP_N
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dir_sel,
    input  logic             sdata,
    output logic             word_clk,
    output logic [OUT_W-1:0] dout
);

    logic              frame_ok;
    logic              take;
    logic [DATA_W-1:0] payload;
    logic [OUT_W-1:0]  mapped;

    fwd_window #(.FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W)) u_window (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .shift_en (en),
        .sdata    (sdata),
        .frame_ok (frame_ok),
        .payload  (payload)
    );

    fwd_ctrl #(.FRAME_LEN(FRAME_LEN), .WAKE_CYC(WAKE_CYC)) u_ctrl (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .en       (en),
        .dir_sel  (dir_sel),
        .frame_ok (frame_ok),
        .take     (take),
        .wclk     (word_clk)
    );

    fwd_posmap #(.DATA_W(DATA_W), .GAP_LO(GAP_LO), .GAP_N(GAP_N), .OUT_W(OUT_W)) u_map (
        .payload (payload),
        .word    (mapped)
    );

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else if (take) dout <= mapped;
    end

    assert_dout_hold_R6: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !$fell(word_clk) |-> $stable(dout));

    assert_gap_zero_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(word_clk) |-> (dout[GAP_LO+GAP_N-1:GAP_LO] == '0));

endmodule

// File: tb/framed_word_deser_tb.sv
`timescale 1ns/1ps
module framed_word_deser_tb;

    logic        bit_clk = 1'b0;
    logic        rst_n, en, dir_sel, sdata;
    logic        word_clk;
    logic [23:0] dout;

    int n_checks = 0;
    int n_fail   = 0;

    int          rec_n = 0;
    int          rec_len [64];
    logic [23:0] rec_val [64];
    int          run = 0;

    always #10 bit_clk = ~bit_clk;

    framed_word_deser u_dut (
        .bit_clk (bit_clk), .rst_n (rst_n), .en (en), .dir_sel (dir_sel),
        .sdata (sdata), .word_clk (word_clk), .dout (dout)
    );

    // low-run recorder on word_clk
    always @(negedge bit_clk) begin
        if (word_clk === 1'b0) begin
            run = run + 1;
        end else if (run > 0) begin
            if (rec_n < 64) begin
                rec_len[rec_n] = run;
                rec_val[rec_n] = dout;
            end
            rec_n = rec_n + 1;
            run = 0;
        end
    end

    // kind: 0 good, 1 bad, 2 idle; emit: expected word output
    localparam logic [24:0] VEC [13] = '{
        {2'd0, 1'b0, 22'h15A5C3},
        {2'd0, 1'b1, 22'h3FFFFF},
        {2'd0, 1'b1, 22'h000001},
        {2'd1, 1'b0, 22'h0F0F0F},
        {2'd0, 1'b1, 22'h2C3E1B},
        {2'd1, 1'b0, 22'h111111},
        {2'd1, 1'b0, 22'h222222},
        {2'd2, 1'b0, 22'h000000},
        {2'd2, 1'b0, 22'h000000},
        {2'd0, 1'b0, 22'h123456},
        {2'd0, 1'b1, 22'h3A5A5A},
        {2'd0, 1'b1, 22'h200000},
        {2'd2, 1'b0, 22'h000000}
    };

    function automatic logic [23:0] map22(input logic [21:0] d);
        logic [23:0] r;
        r[19:0]  = d[19:0];
        r[21:20] = 2'b00;
        r[22]    = d[20];
        r[23]    = d[21];
        return r;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge bit_clk);
        sdata = b;
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    // R4 frame order: start, data 1..22, two spare bits, stop
    task automatic send_word(input logic [1:0] kind, input logic [21:0] d,
                             output logic [23:0] snap);
        logic [25:0] f;
        f[0] = (kind != 2'd2);
        for (int k = 0; k < 22; k++) f[k+1] = (kind == 2'd2) ? 1'b0 : d[k];
        f[23] = (kind == 2'd2) ? 1'b0 : d[0];
        f[24] = (kind == 2'd2) ? 1'b0 : ~d[0];
        f[25] = (kind == 2'd1);
        for (int j = 0; j < 26; j++) begin
            send_bit(f[j]);
            if (j == 3) snap = dout;
        end
    endtask

    initial begin
        repeat (200000) @(posedge bit_clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] snap, exp_prev;
        logic [23:0] exp_val [16];
        int exp_n, base;

        rst_n = 1'b0; en = 1'b0; dir_sel = 1'b0; sdata = 1'b0;
        repeat (3) @(negedge bit_clk);
        check(dout == 24'h0, "R1 dout in reset", dout, 0);
        check(word_clk == 1'b1, "R1 word_clk in reset", word_clk, 1);
        rst_n = 1'b1;
        idle_bits(5);
        check(rec_n == 0, "R10 no pulse while disabled", rec_n, 0);

        en = 1'b1;
        idle_bits(40);
        check(rec_n == 1, "R3 one wake pulse", rec_n, 1);
        check(rec_len[0] == 4, "R3 wake low length", rec_len[0], 4);

        // table walk: R4 R5 R6 R7 R8 R9
        base = rec_n;
        exp_n = 0;
        exp_prev = 24'h0;
        for (int k = 0; k < 13; k++) begin
            send_word(VEC[k][24:23], VEC[k][21:0], snap);
            if (k > 0) check(snap == exp_prev, "R7 dout after prior frame", snap, exp_prev);
            if (VEC[k][22]) begin
                exp_prev = map22(VEC[k][21:0]);
                exp_val[exp_n] = exp_prev;
                exp_n++;
            end
        end
        check(rec_n - base == exp_n, "R5 R8 word pulse count", rec_n - base, exp_n);
        for (int i = 0; i < exp_n; i++) begin
            check(rec_len[base+i] == 1, "R6 word pulse width", rec_len[base+i], 1);
            check(rec_val[base+i] == exp_val[i], "R9 word mapping", rec_val[base+i], exp_val[i]);
        end

        // R10 disable and re-enable
        @(negedge bit_clk); en = 1'b0;
        @(negedge bit_clk);
        check(word_clk == 1'b1, "R10 word_clk high when disabled", word_clk, 1);
        check(dout == exp_prev, "R10 dout held when disabled", dout, exp_prev);
        idle_bits(4);
        base = rec_n;
        en = 1'b1;
        idle_bits(40);
        send_word(2'd0, 22'h0ABCDE, snap);
        send_word(2'd0, 22'h155555, snap);
        send_word(2'd2, 22'h0, snap);
        check(rec_n - base == 2, "R10 wake plus one word", rec_n - base, 2);
        check(rec_len[base] == 4, "R3 wake length again", rec_len[base], 4);
        check(rec_val[base+1] == map22(22'h155555), "R10 relock word",
              rec_val[base+1], map22(22'h155555));

        // R2 idle role
        @(negedge bit_clk); rst_n = 1'b0; dir_sel = 1'b1;
        repeat (2) @(negedge bit_clk);
        check(dout == 24'h0, "R1 dout after second reset", dout, 0);
        rst_n = 1'b1;
        base = rec_n;
        idle_bits(40);
        for (int i = 0; i < 3; i++) send_word(2'd0, 22'h2AAAAA, snap);
        send_word(2'd2, 22'h0, snap);
        check(rec_n == base, "R2 idle role no pulses", rec_n - base, 0);
        check(dout == 24'h0, "R2 idle role dout", dout, 0);
        check(word_clk == 1'b1, "R2 idle role word_clk", word_clk, 1);

        // R2 later dir_sel change ignored
        @(negedge bit_clk); rst_n = 1'b0; dir_sel = 1'b0;
        repeat (2) @(negedge bit_clk);
        rst_n = 1'b1;
        base = rec_n;
        idle_bits(2);
        dir_sel = 1'b1;
        idle_bits(40);
        send_word(2'd0, 22'h0C0C0C, snap);
        send_word(2'd0, 22'h3C3C3C, snap);
        send_word(2'd2, 22'h0, snap);
        check(rec_n - base == 2, "R2 dir change ignored", rec_n - base, 2);
        check(rec_val[base+1] == map22(22'h3C3C3C), "R2 word after dir change",
              rec_val[base+1], map22(22'h3C3C3C));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule